// File: doc/BRIEF.md
# External Bus Chip-Select and Wait-State Controller

This block turns one request from an on-chip master into a complete cycle on a shared external memory bus. The upper bits of a 25-bit byte address (32 MB of space) are compared against six programmable windows. The first window that matches drives its active-low chip select for the whole access. Each window carries its own configuration: enable, base, size mask, wait-state count, data width and byte order. Window sizes are whole multiples of a 64 KB granule.

A bus cycle lasts two clocks plus the selected window's wait count, which runs from 0 to 7. A 16-bit access to a window with an 8-bit data path is split into two back-to-back byte cycles. A halfword access to the one window marked little-endian has its two bytes exchanged. An address that hits no enabled window still takes the basic two-clock slot, but it asserts nothing on the bus and returns an error flag. The master sees `req_ready` high whenever a new request can be taken. The result comes back as a one-clock `rsp_valid` pulse that carries the read data and the error flag.

Top module: `ext_bus_ctl`

## Requirements
- R1: Window i matches when `cfg_en[i]` is 1 and address bits 24..16 equal `cfg_base[i]` in every bit position where `cfg_mask[i]` is 0. A mask bit of 1 makes that 64 KB-granule address bit a don't-care. A matching access returns `rsp_err` = 0.
- R2: When several windows match, the one with the lowest index is selected.
- R3: `bus_cs_n` bit i is driven low for the selected window only. It stays low and unchanged for every clock of the access, including wait states and both halves of a split access. At most one bit of `bus_cs_n` is ever low, and no strobe is asserted while all chip selects are high.
- R4: If a request is accepted at clock edge E, each bus cycle occupies 2+W clocks, where W is the window's `cfg_wait` value. `rsp_valid` is high for exactly one clock, starting at edge E + N·(2+W), where N is the number of bus cycles. Before that, `rsp_valid` stays low.
- R5: A window with `cfg_wide` = 1 takes one bus cycle. `bus_addr` bit 0 is 0, and `bus_we_n[1]` (upper lane, even byte) and `bus_we_n[0]` (lower lane, odd byte) go low for the enabled bytes. `req_be[1]` enables the even byte and `req_be[0]` the odd byte.
- R6: A window with `cfg_wide` = 0 moves data on `bus_dout`/`bus_din` bits 15..8 only. Each enabled byte gets its own bus cycle, with the even byte first and `bus_addr` bit 0 equal to the byte index. On a write, only `bus_we_n[1]` goes low.
- R7: `cfg_le_sel` names the little-endian window; values 1 to 5 are valid and any other value names none. For a two-byte access to that window, the request's upper and lower data bytes are exchanged on write and on read. Single-byte accesses to that window are not exchanged.
- R8: An address that matches no enabled window drives no chip select and no strobe. It completes after 2 clocks with `rsp_err` = 1 and `rsp_rdata` = 0.
- R9: `req_be` = 00 is treated exactly like 11.
- R10: `rsp_rdata` carries the read bytes in their request lanes. Lanes whose byte was not enabled read as 0.
- R11: `req_ready` is low while a bus cycle is in progress. It is high when idle and during the response clock, and a request may be accepted in either of those states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 6 | Per-window enable |
| cfg_base | input | 54 | Per-window base, address bits 24..16 (9 bits each, window i at bits 9i+8..9i) |
| cfg_mask | input | 54 | Per-window don't-care mask over the same bits |
| cfg_wait | input | 18 | Per-window wait count, 3 bits each |
| cfg_wide | input | 6 | Per-window data width: 1 = 16 bit, 0 = 8 bit |
| cfg_le_sel | input | 3 | Index of the little-endian window (1..5, otherwise none) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Byte address |
| req_be | input | 2 | Byte enables: [1] even byte, [0] odd byte |
| req_wdata | input | 16 | Write data, [15:8] even byte |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Access matched no window |
| rsp_rdata | output | 16 | Read data |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_addr | output | 25 | External address |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 2 | Active-low write strobes per lane |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Read data from the bus |

## Verification
The bench puts a new request on the bus at a falling edge and lets it be taken at the next rising edge. It then follows the transaction one falling edge at a time, so clock t after acceptance lies in bus cycle t/(2+W). In each of those clocks it checks the chip selects, address, strobes and write data that the requirements predict. The response is looked for at exactly the falling edge N·(2+W) after acceptance, and the bench confirms it has dropped one clock later. The external device is modelled as a fixed function of `bus_addr`, which lets every expected read value be computed arithmetically.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_RESP = 2'd2
   } ebc_state_e;

   function automatic logic [15:0] swap_bytes(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

endpackage

// File: rtl/ebc_area_decode.sv
module ebc_area_decode #(
   parameter int AREA_W = 9,
   parameter int NAREA  = 6,
   parameter int IDX_W  = 3
) (
   input  logic [AREA_W-1:0]       addr_hi,
   input  logic [NAREA-1:0]        en,
   input  logic [NAREA*AREA_W-1:0] base,
   input  logic [NAREA*AREA_W-1:0] mask,
   output logic                    hit,
   output logic [NAREA-1:0]        sel_oh,
   output logic [IDX_W-1:0]        sel_idx
);

   logic [NAREA-1:0] match;

   // One comparator per window; masked bits are don't-care
   for (genvar i = 0; i < NAREA; i++) begin : g_win
      assign match[i] = en[i] &&
         (((addr_hi ^ base[i*AREA_W +: AREA_W]) & ~mask[i*AREA_W +: AREA_W]) == '0);
   end

   // Lowest index wins: scan downward so the last hit written is the lowest
   always_comb begin
      hit     = |match;
      sel_idx = '0;
      sel_oh  = '0;
      for (int i = NAREA - 1; i >= 0; i--) begin
         if (match[i]) begin
            sel_idx   = IDX_W'(i);
            sel_oh    = '0;
            sel_oh[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq #(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              two_beats,
   input  logic [WAIT_W-1:0] wait_in,
   output logic              run,
   output logic              resp,
   output logic              beat,
   output logic              cyc_end
);
   import ebc_pkg::*;

   localparam logic [WAIT_W:0] ONE = (WAIT_W+1)'(1);

   ebc_state_e        st;
   logic [WAIT_W:0]   cnt;
   logic [WAIT_W-1:0] wait_q;
   logic              two_q;

   assign run     = (st == ST_RUN);
   assign resp    = (st == ST_RESP);
   assign cyc_end = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         wait_q <= '0;
         two_q  <= 1'b0;
         beat   <= 1'b0;
      end else begin
         case (st)
            ST_IDLE, ST_RESP: begin
               if (start) begin
                  st     <= ST_RUN;
                  cnt    <= {1'b0, wait_in} + ONE;
                  wait_q <= wait_in;
                  two_q  <= two_beats;
                  beat   <= 1'b0;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_RUN: begin
               if (cnt == '0) begin
                  if (two_q && !beat) begin
                     beat <= 1'b1;
                     cnt  <= {1'b0, wait_q} + ONE;
                  end else begin
                     st <= ST_RESP;
                  end
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R4: the per-cycle counter never exceeds the latched wait plus one
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= ({1'b0, wait_q} + ONE)));

   // R4: the completion is a single-clock pulse
   p_resp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      resp |=> !resp);

   // R4: a cycle is not abandoned before its last clock
   p_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cyc_end) |=> run);

endmodule

// File: rtl/ebc_lane.sv
module ebc_lane (
   input  logic        wide,
   input  logic        le,
   input  logic        k,
   input  logic [1:0]  be,
   input  logic [15:0] wdata,
   input  logic [15:0] din,
   output logic [15:0] dout,
   output logic [15:0] rval,
   output logic [1:0]  rlanes
);
   import ebc_pkg::*;

   logic to_low;

   always_comb begin
      to_low = k ^ le;
      if (wide) begin
         dout   = le ? swap_bytes(wdata) : wdata;
         rval   = le ? swap_bytes(din) : din;
         rlanes = be;
      end else begin
         dout   = {(to_low ? wdata[7:0] : wdata[15:8]), 8'h00};
         rval   = to_low ? {8'h00, din[15:8]} : {din[15:8], 8'h00};
         rlanes = to_low ? 2'b01 : 2'b10;
      end
   end

endmodule

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl #(
   parameter int ADDR_W    = 25,
   parameter int GRAN_BITS = 16,
   parameter int NAREA     = 6,
   parameter int WAIT_W    = 3,
   parameter int LE_LO     = 1,
   parameter int LE_HI     = 5
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NAREA-1:0]                     cfg_en,
   input  logic [NAREA*(ADDR_W-GRAN_BITS)-1:0]  cfg_base,
   input  logic [NAREA*(ADDR_W-GRAN_BITS)-1:0]  cfg_mask,
   input  logic [NAREA*WAIT_W-1:0]              cfg_wait,
   input  logic [NAREA-1:0]                     cfg_wide,
   input  logic [$clog2(NAREA)-1:0]             cfg_le_sel,
   input  logic                                 req_valid,
   output logic                                 req_ready,
   input  logic                                 req_write,
   input  logic [ADDR_W-1:0]                    req_addr,
   input  logic [1:0]                           req_be,
   input  logic [15:0]                          req_wdata,
   output logic                                 rsp_valid,
   output logic                                 rsp_err,
   output logic [15:0]                          rsp_rdata,
   output logic [NAREA-1:0]                     bus_cs_n,
   output logic [ADDR_W-1:0]                    bus_addr,
   output logic                                 bus_rd_n,
   output logic [1:0]                           bus_we_n,
   output logic [15:0]                          bus_dout,
   output logic                                 bus_doe,
   input  logic [15:0]                          bus_din
);

   localparam int AREA_W = ADDR_W - GRAN_BITS;
   localparam int IDX_W  = $clog2(NAREA);
   localparam logic [IDX_W-1:0] LE_LO_V = IDX_W'(LE_LO);
   localparam logic [IDX_W-1:0] LE_HI_V = IDX_W'(LE_HI);

   initial begin
      assert (GRAN_BITS > 0 && AREA_W > 0 && NAREA >= 2 && WAIT_W >= 1 &&
              LE_LO <= LE_HI && LE_HI < NAREA)
         else $error("ext_bus_ctl: inconsistent parameters");
   end

   // ---------------- decode of the incoming request ----------------
   logic              dec_hit;
   logic [NAREA-1:0]  dec_oh;
   logic [IDX_W-1:0]  dec_idx;
   logic [WAIT_W-1:0] dec_wait;
   logic              dec_wide, dec_le;
   logic [1:0]        be_n;
   logic              start;

   ebc_area_decode #(.AREA_W(AREA_W), .NAREA(NAREA), .IDX_W(IDX_W)) u_dec (
      .addr_hi (req_addr[ADDR_W-1:GRAN_BITS]),
      .en      (cfg_en),
      .base    (cfg_base),
      .mask    (cfg_mask),
      .hit     (dec_hit),
      .sel_oh  (dec_oh),
      .sel_idx (dec_idx)
   );

   assign be_n     = (req_be == 2'b00) ? 2'b11 : req_be;
   assign dec_wait = dec_hit ? cfg_wait[dec_idx*WAIT_W +: WAIT_W] : '0;
   assign dec_wide = dec_hit ? cfg_wide[dec_idx] : 1'b1;
   assign dec_le   = dec_hit && (dec_idx == cfg_le_sel) &&
                     (cfg_le_sel >= LE_LO_V) && (cfg_le_sel <= LE_HI_V) &&
                     (be_n == 2'b11);
   assign start    = req_valid && req_ready;

   // ---------------- sequencing ----------------
   logic run, resp, beat, cyc_end;

   ebc_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .two_beats (dec_hit && !dec_wide && (be_n == 2'b11)),
      .wait_in   (dec_wait),
      .run       (run),
      .resp      (resp),
      .beat      (beat),
      .cyc_end   (cyc_end)
   );

   // ---------------- per-access latches ----------------
   logic              l_write, l_wide, l_le, l_hit;
   logic [ADDR_W-1:0] l_addr;
   logic [1:0]        l_be;
   logic [15:0]       l_wdata, rdata;
   logic [NAREA-1:0]  l_cs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_write <= 1'b0;
         l_wide  <= 1'b1;
         l_le    <= 1'b0;
         l_hit   <= 1'b0;
         l_addr  <= '0;
         l_be    <= 2'b11;
         l_wdata <= '0;
         l_cs    <= '0;
      end else if (start) begin
         l_write <= req_write;
         l_wide  <= dec_wide;
         l_le    <= dec_le;
         l_hit   <= dec_hit;
         l_addr  <= req_addr;
         l_be    <= be_n;
         l_wdata <= req_wdata;
         l_cs    <= dec_hit ? dec_oh : '0;
      end
   end

   // ---------------- byte lanes ----------------
   logic        k, active;
   logic [15:0] lane_dout, rval, rmask;
   logic [1:0]  rlanes;

   assign k      = beat | ~l_be[1];
   assign active = run && l_hit;

   ebc_lane u_lane (
      .wide   (l_wide),
      .le     (l_le),
      .k      (k),
      .be     (l_be),
      .wdata  (l_wdata),
      .din    (bus_din),
      .dout   (lane_dout),
      .rval   (rval),
      .rlanes (rlanes)
   );

   assign rmask = {{8{rlanes[1]}}, {8{rlanes[0]}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (start)
         rdata <= '0;
      else if (cyc_end && active && !l_write)
         rdata <= (rdata & ~rmask) | (rval & rmask);
   end

   // ---------------- outputs ----------------
   assign req_ready = !run;
   assign rsp_valid = resp;
   assign rsp_err   = resp && !l_hit;
   assign rsp_rdata = resp ? rdata : '0;

   assign bus_cs_n  = active ? ~l_cs : '1;
   assign bus_addr  = active ? {l_addr[ADDR_W-1:1], (l_wide ? 1'b0 : k)} : '0;
   assign bus_rd_n  = !(active && !l_write);
   assign bus_we_n  = (active && l_write) ? (l_wide ? ~l_be : 2'b01) : 2'b11;
   assign bus_doe   = active && l_write;
   assign bus_dout  = bus_doe ? lane_dout : '0;

   // R3: never more than one chip select low
   p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));

   // R3: chip select unchanged across all clocks of one access
   p_cs_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(bus_cs_n));

   // R3: a strobe implies a chip select
   p_strobe_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || (bus_we_n != 2'b11)) |-> !(&bus_cs_n));

   // R6: address holds within one byte cycle
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(cyc_end)) |-> $stable(bus_addr));

   // R8: an error completion followed a clock with no chip select
   p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> $past(&bus_cs_n));

endmodule

// File: tb/ext_bus_ctl_test.sv
module ext_bus_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_en, cfg_wide;
   logic [53:0] cfg_base, cfg_mask;
   logic [17:0] cfg_wait;
   logic [2:0]  cfg_le_sel;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic        req_ready, rsp_valid, rsp_err, bus_rd_n, bus_doe;
   logic [24:0] req_addr = '0, bus_addr;
   logic [1:0]  req_be = 2'b11, bus_we_n;
   logic [15:0] req_wdata = '0, rsp_rdata, bus_dout, bus_din;
   logic [5:0]  bus_cs_n;

   logic [8:0] b_base [6];
   logic [8:0] b_mask [6];
   logic [2:0] b_wait [6];
   bit         b_en   [6];
   bit         b_wide [6];
   int         le_sel;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 6; i++) begin
         cfg_base[i*9 +: 9] = b_base[i];
         cfg_mask[i*9 +: 9] = b_mask[i];
         cfg_wait[i*3 +: 3] = b_wait[i];
         cfg_en[i]          = b_en[i];
         cfg_wide[i]        = b_wide[i];
      end
      cfg_le_sel = 3'(le_sel);
   end

   function automatic logic [15:0] dev(input logic [24:0] ad);
      return {ad[7:0] ^ 8'h5A, ad[15:8] ^ ad[7:0] ^ 8'h3C};
   endfunction

   assign bus_din = dev(bus_addr);

   ext_bus_ctl uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
      .cfg_wait(cfg_wait), .cfg_wide(cfg_wide), .cfg_le_sel(cfg_le_sel),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
      .bus_we_n(bus_we_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_din(bus_din)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int area_of(input logic [24:0] ad, output int nm);
      int r = -1;
      nm = 0;
      for (int i = 0; i < 6; i++) begin
         if (b_en[i] && (((ad[24:16] ^ b_base[i]) & ~b_mask[i]) == 9'd0)) begin
            nm++;
            if (r < 0) r = i;
         end
      end
      return r;
   endfunction

   task automatic run_acc(input logic [24:0] addr, input bit wr,
                          input logic [1:0] be, input logic [15:0] wd);
      int a, nm, w, n, len, kk;
      bit hit, wide, le;
      logic [1:0]  bn, ewe;
      logic [15:0] er, raw, ed;
      logic [5:0]  ecs;
      logic [24:0] ea;
      a    = area_of(addr, nm);
      hit  = (a >= 0);
      bn   = (be == 2'b00) ? 2'b11 : be;
      wide = hit ? b_wide[a] : 1'b1;
      w    = hit ? int'(b_wait[a]) : 0;
      le   = hit && (a == le_sel) && (le_sel >= 1) && (le_sel <= 5) && (bn == 2'b11);
      n    = (hit && !wide && bn == 2'b11) ? 2 : 1;
      len  = 2 + w;
      // expected read data
      er = 16'h0000;
      if (hit && !wr) begin
         if (wide) begin
            raw = dev({addr[24:1], 1'b0});
            if (le) raw = {raw[7:0], raw[15:8]};
            er = raw & {{8{bn[1]}}, {8{bn[0]}}};
         end else begin
            for (int kb = 0; kb < 2; kb++) begin
               if (bn[1-kb]) begin
                  raw = dev({addr[24:1], kb[0]});
                  if ((kb[0] ^ le) == 1'b0) er[15:8] = raw[15:8];
                  else                      er[7:0]  = raw[15:8];
               end
            end
         end
      end
      chk(req_ready == 1'b1, "R11 ready before request", 32'(req_ready), 32'd1);
      req_addr  = addr;
      req_write = wr;
      req_be    = be;
      req_wdata = wd;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < n * len; t++) begin
         kk  = wide ? 0 : (((t / len) == 0) ? (bn[1] ? 0 : 1) : 1);
         ecs = hit ? ~(6'b000001 << a) : 6'h3F;
         chk(bus_cs_n == ecs,
             !hit ? "R8 miss drives no select" :
             (t > 0 ? "R3 select held" :
             (nm > 1 ? "R2 overlap priority" : "R1 window decode")),
             32'(bus_cs_n), 32'(ecs));
         chk(rsp_valid == 1'b0, "R4 no early response", 32'(rsp_valid), 32'd0);
         chk(req_ready == 1'b0, "R11 busy during cycle", 32'(req_ready), 32'd0);
         if (hit) begin
            ea = {addr[24:1], (wide ? 1'b0 : kk[0])};
            chk(bus_addr == ea, wide ? "R5 wide address" : "R6 byte address",
                32'(bus_addr), 32'(ea));
         end
         ewe = (hit && wr) ? (wide ? ~bn : 2'b01) : 2'b11;
         chk(bus_we_n == ewe,
             !hit ? "R8 miss no write strobe" :
             (be == 2'b00 ? "R9 zero enables as full" :
             (wide ? "R5 wide strobes" : "R6 byte strobes")),
             32'(bus_we_n), 32'(ewe));
         chk(bus_rd_n == !(hit && !wr), !hit ? "R8 miss no read strobe" : "R5 read strobe",
             32'(bus_rd_n), 32'(!(hit && !wr)));
         if (hit && wr) begin
            if (wide) ed = le ? {wd[7:0], wd[15:8]} : wd;
            else      ed = {((kk[0] ^ le) ? wd[7:0] : wd[15:8]), 8'h00};
            chk(bus_doe && bus_dout == ed,
                le ? "R7 little-endian write" : (wide ? "R5 wide write data" : "R6 byte write data"),
                {15'd0, bus_doe, bus_dout}, {15'd1, 1'b1, ed});
         end
         @(negedge clk);
      end
      chk(rsp_valid == 1'b1, "R4 response timing", 32'(rsp_valid), 32'd1);
      chk(rsp_err == !hit, hit ? "R1 no error on hit" : "R8 error flag",
          32'(rsp_err), 32'(!hit));
      if (!wr)
         chk(rsp_rdata == er,
             !hit ? "R8 miss read data" : (le ? "R7 little-endian read" :
             (be == 2'b00 ? "R9 zero enables read" : "R10 read data lanes")),
             32'(rsp_rdata), 32'(er));
      chk(req_ready == 1'b1, "R11 ready in response", 32'(req_ready), 32'd1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R4 single pulse", 32'(rsp_valid), 32'd0);
   endtask

   logic [24:0] alist [9];

   initial begin
      // window 0: 1 MB wide, 0 waits; window 4 shadowed by it
      b_base[0] = 9'h000; b_mask[0] = 9'h00F; b_wait[0] = 3'd0; b_en[0] = 1; b_wide[0] = 1;
      b_base[1] = 9'h010; b_mask[1] = 9'h000; b_wait[1] = 3'd1; b_en[1] = 1; b_wide[1] = 0;
      b_base[2] = 9'h020; b_mask[2] = 9'h001; b_wait[2] = 3'd3; b_en[2] = 1; b_wide[2] = 1;
      b_base[3] = 9'h100; b_mask[3] = 9'h0FF; b_wait[3] = 3'd7; b_en[3] = 1; b_wide[3] = 0;
      b_base[4] = 9'h005; b_mask[4] = 9'h000; b_wait[4] = 3'd2; b_en[4] = 1; b_wide[4] = 1;
      b_base[5] = 9'h030; b_mask[5] = 9'h000; b_wait[5] = 3'd4; b_en[5] = 0; b_wide[5] = 1;
      le_sel = 2;
      alist[0] = 25'h0000000; alist[1] = 25'h0050003; alist[2] = 25'h0100001;
      alist[3] = 25'h0210006; alist[4] = 25'h1234567; alist[5] = 25'h0300000;
      alist[6] = 25'h00FFFFE; alist[7] = 25'h0110000; alist[8] = 25'h0200009;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs_n == 6'h3F, "R3 reset selects high", 32'(bus_cs_n), 32'h3F);
      chk(bus_rd_n && bus_we_n == 2'b11, "R3 reset strobes high",
          32'({bus_rd_n, bus_we_n}), 32'h7);
      chk(rsp_valid == 1'b0, "R4 reset no response", 32'(rsp_valid), 32'd0);
      chk(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 32'd1);
      for (int ph = 0; ph < 3; ph++) begin
         le_sel = (ph == 0) ? 2 : ((ph == 1) ? 1 : 0);
         for (int ai = 0; ai < 9; ai++)
            for (int b = 0; b < 4; b++)
               for (int wr = 0; wr < 2; wr++)
                  run_acc(alist[ai], wr[0], b[1:0], 16'hA1B2 ^ 16'(ai * 16'h0731 + b * 3));
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule